// File: doc/BRIEF.md
# Floppy Controller Command Front End

This block is the host-facing register interface of a simplified floppy disk controller on a PC-style byte bus. The host writes a control register to switch drive motors, enable DMA, select a drive, and hold the controller in reset or release it. It polls a main status byte to see whether the data port is waiting for command bytes or holding result bytes. Commands and results move through that one data port.

Four commands are decoded from the low five bits of the first command byte: parameter setup (0x03), recalibrate (0x07), seek (0x0F) and interrupt sense (0x08). Any other opcode is treated as invalid. Each of the four drives keeps its present track, a pending-interrupt flag and a status-0 byte. One level-sensitive interrupt request output tells the host that at least one drive has an event waiting. No media is modelled. Head motion completes at once, and there is no data transfer or DMA traffic.

When the controller leaves reset, every drive reports a "became not ready" event. The host drains these one interrupt sense at a time. The lowest-numbered pending drive answers first, and the interrupt line falls only when none is left.

Top module: `fdc_front`

## Requirements
- R1: After the asynchronous reset the status byte reads 0x80, irq is low, motor_en, dma_en and drive_sel are all zero, and a data-port read returns 0x80.
- R2: A write to the control register (address 0) drives motor_en[i] from bit 4+i, dma_en from bit 3 and drive_sel from bits 1:0, starting the cycle after the write.
- R3: While control bit 2 is 0 the controller is held: irq is low, the status byte reads 0x80, and data-port writes are ignored.
- R4: A control write that takes bit 2 from 0 to 1 clears any partly received command and all queued results. It marks all four drives pending with status-0 byte 0xC0 and raises irq two cycles after the write.
- R5: Recalibrate (0x07, then a byte whose bits 1:0 give the drive) sets that drive's track to 0 and its status-0 byte to the drive number. It marks the drive pending, raises irq and queues no result.
- R6: Seek (0x0F, then a byte with head in bit 2 and drive in bits 1:0, then the cylinder) sets the drive's track to the cylinder and its status-0 byte to bits 2:0 of the second byte. It marks the drive pending, raises irq and queues no result.
- R7: Interrupt sense (0x08) picks the lowest-numbered pending drive and queues two result bytes, its status-0 byte and then its track. It clears that drive's pending flag, and irq stays high only if another drive is still pending.
- R8: Interrupt sense with no drive pending queues the single byte 0x80 and drives irq low.
- R9: The status byte (address 1) reads 0xD0 while result bytes are queued (bit 7 ready, bit 6 controller-to-host, bit 4 busy) and 0x80 otherwise. Each data read pops one byte, and reading the last byte returns the status to 0x80.
- R10: A data-port read (address 2) with no result queued returns 0x80 and changes no state.
- R11: Parameter setup (0x03 followed by two bytes) stores the two bytes on step_cfg, the first in the upper half, and queues no result.
- R12: A first command byte whose low five bits match no supported opcode is a complete one-byte command and queues the single result byte 0x80.
- R13: Data-port writes made while result bytes are queued are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Interrupt request, high while a drive event is pending |
| motor_en | output | 4 | Motor enable per drive |
| dma_en | output | 1 | DMA enable from the control register |
| drive_sel | output | 2 | Selected drive |
| step_cfg | output | 16 | Bytes stored by parameter setup |

## Verification
The bench goes after the reset-release drain. Four sense commands must each report 0xC0. A design that cleared every pending flag on the first sense, or dropped irq early, would show a low irq or an unexpected 0x80 on the second sense. Two seeks to different drives check that the lowest drive answers first and that each reported track belongs to the drive that answered, not to drive 0. The bench also writes a command byte while results are waiting and re-enters hold with irq high. A design that accepted the stray byte would queue extra results, and one that kept irq during hold would fail the low-irq check.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  localparam int NUM_DRIVES = 4;
  localparam int DSEL_W     = $clog2(NUM_DRIVES);
  localparam int BYTE_W     = 8;
  localparam int MAX_CMD    = 3;
  localparam int CNT_W      = $clog2(MAX_CMD + 1);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam logic [4:0] OP_SPECIFY = 5'h03;
  localparam logic [4:0] OP_RECAL   = 5'h07;
  localparam logic [4:0] OP_SENSE   = 5'h08;
  localparam logic [4:0] OP_SEEK    = 5'h0F;

  localparam logic [BYTE_W-1:0] ST0_NOT_READY = 8'hC0;
  localparam logic [BYTE_W-1:0] RES_INVALID   = 8'h80;
  localparam logic [BYTE_W-1:0] READ_IDLE     = 8'h80;
  localparam logic [BYTE_W-1:0] READ_NONE     = 8'hFF;

  localparam int MSR_READY = 7;
  localparam int MSR_TOCPU = 6;
  localparam int MSR_BUSY  = 4;

  // total byte count of a command, decided by its first byte
  function automatic logic [CNT_W-1:0] cmd_len(input logic [4:0] op);
    case (op)
      OP_SPECIFY: cmd_len = CNT_W'(3);
      OP_RECAL:   cmd_len = CNT_W'(2);
      OP_SEEK:    cmd_len = CNT_W'(3);
      default:    cmd_len = CNT_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/fdc_ctrl_reg.sv
module fdc_ctrl_reg
  import fdc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [NUM_DRIVES-1:0] motor_en,
  output logic                  dma_en,
  output logic [DSEL_W-1:0]     drive_sel,
  output logic                  hold,
  output logic                  soft_rst
);

  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic              soft_q, soft_d;

  always_comb begin
    ctrl_d = ctrl_q;
    soft_d = 1'b0;
    if (wr_en) begin
      ctrl_d = wdata;
      soft_d = wdata[2] & ~ctrl_q[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      soft_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      soft_q <= soft_d;
    end
  end

  assign motor_en  = ctrl_q[4 +: NUM_DRIVES];
  assign dma_en    = ctrl_q[3];
  assign drive_sel = ctrl_q[DSEL_W-1:0];
  assign hold      = ~ctrl_q[2];
  assign soft_rst  = soft_q;

endmodule

// File: rtl/fdc_cmd_collect.sv
module fdc_cmd_collect
  import fdc_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            wr_en,
  input  logic [BYTE_W-1:0]               wdata,
  output logic                            fire,
  output logic [MAX_CMD-1:0][BYTE_W-1:0]  cmd_bytes
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] need;
  logic             fire_q, fire_d;

  always_comb begin
    need   = (cnt_q == '0) ? cmd_len(wdata[4:0]) : cmd_len(cmd_bytes[0][4:0]);
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (flush) begin
      cnt_d = '0;
    end else if (wr_en) begin
      if (cnt_q + CNT_W'(1) == need) begin
        cnt_d  = '0;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  for (genvar gi = 0; gi < MAX_CMD; gi++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    logic              load;
    assign load = wr_en && !flush && (cnt_q == CNT_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    byte_q <= '0;
      else if (load) byte_q <= wdata;
    end
    assign cmd_bytes[gi] = byte_q;
  end

  assign fire = fire_q;

endmodule

// File: rtl/fdc_exec.sv
module fdc_exec
  import fdc_pkg::*;
#(
  parameter int TRACK_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            hold,
  input  logic                            soft_rst,
  input  logic                            fire,
  input  logic [MAX_CMD-1:0][BYTE_W-1:0]  cmd_bytes,
  output logic                            irq,
  output logic [2*BYTE_W-1:0]             step_cfg,
  output logic                            res_load,
  output logic                            res_two,
  output logic [BYTE_W-1:0]               res_b0,
  output logic [BYTE_W-1:0]               res_b1
);

  logic [TRACK_W-1:0]    trk_q  [NUM_DRIVES];
  logic [TRACK_W-1:0]    trk_d  [NUM_DRIVES];
  logic [BYTE_W-1:0]     st0_q  [NUM_DRIVES];
  logic [BYTE_W-1:0]     st0_d  [NUM_DRIVES];
  logic [NUM_DRIVES-1:0] pend_q, pend_d;
  logic                  irq_q, irq_d;
  logic [2*BYTE_W-1:0]   spec_q, spec_d;

  logic                  hit;
  logic [DSEL_W-1:0]     hit_idx;
  logic [NUM_DRIVES-1:0] hit_mask;
  logic [DSEL_W-1:0]     tgt;
  logic [4:0]            op;

  assign op  = cmd_bytes[0][4:0];
  assign tgt = cmd_bytes[1][DSEL_W-1:0];

  wire unused_cmd_bits = ^{cmd_bytes[0][7:5], cmd_bytes[1][7:3]};

  // lowest-numbered pending drive wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        hit     = 1'b1;
        hit_idx = DSEL_W'(i);
      end
    end
    hit_mask = NUM_DRIVES'(1) << hit_idx;
  end

  always_comb begin
    trk_d    = trk_q;
    st0_d    = st0_q;
    pend_d   = pend_q;
    irq_d    = irq_q;
    spec_d   = spec_q;
    res_load = 1'b0;
    res_two  = 1'b0;
    res_b0   = '0;
    res_b1   = '0;
    if (hold) begin
      irq_d = 1'b0;
    end else if (soft_rst) begin
      for (int i = 0; i < NUM_DRIVES; i++) begin
        pend_d[i] = 1'b1;
        st0_d[i]  = ST0_NOT_READY;
      end
      irq_d = 1'b1;
    end else if (fire) begin
      case (op)
        OP_SPECIFY: spec_d = {cmd_bytes[1], cmd_bytes[2]};
        OP_RECAL: begin
          trk_d[tgt]  = '0;
          st0_d[tgt]  = BYTE_W'(tgt);
          pend_d[tgt] = 1'b1;
          irq_d       = 1'b1;
        end
        OP_SEEK: begin
          trk_d[tgt]  = TRACK_W'(cmd_bytes[2]);
          st0_d[tgt]  = BYTE_W'(cmd_bytes[1][2:0]);
          pend_d[tgt] = 1'b1;
          irq_d       = 1'b1;
        end
        OP_SENSE: begin
          res_load = 1'b1;
          if (hit) begin
            res_two         = 1'b1;
            res_b0          = st0_q[hit_idx];
            res_b1          = BYTE_W'(trk_q[hit_idx]);
            pend_d[hit_idx] = 1'b0;
            irq_d           = |(pend_q & ~hit_mask);
          end else begin
            res_b0 = RES_INVALID;
            irq_d  = 1'b0;
          end
        end
        default: begin
          res_load = 1'b1;
          res_b0   = RES_INVALID;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DRIVES; i++) begin
        trk_q[i] <= '0;
        st0_q[i] <= '0;
      end
      pend_q <= '0;
      irq_q  <= 1'b0;
      spec_q <= '0;
    end else begin
      trk_q  <= trk_d;
      st0_q  <= st0_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
      spec_q <= spec_d;
    end
  end

  assign irq      = irq_q;
  assign step_cfg = spec_q;

endmodule

// File: rtl/fdc_result_q.sv
module fdc_result_q
  import fdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic              two,
  input  logic [BYTE_W-1:0] b0,
  input  logic [BYTE_W-1:0] b1,
  input  logic              pop,
  output logic              to_cpu,
  output logic [1:0]        count,
  output logic [BYTE_W-1:0] head
);

  logic [1:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] e0_q, e0_d, e1_q, e1_d;

  always_comb begin
    cnt_d = cnt_q;
    e0_d  = e0_q;
    e1_d  = e1_q;
    if (flush) begin
      cnt_d = '0;
    end else if (load) begin
      e0_d  = b0;
      e1_d  = b1;
      cnt_d = two ? 2'd2 : 2'd1;
    end else if (pop) begin
      e0_d  = e1_q;
      cnt_d = cnt_q - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      e0_q  <= '0;
      e1_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      e0_q  <= e0_d;
      e1_q  <= e1_d;
    end
  end

  assign to_cpu = (cnt_q != 2'd0);
  assign count  = cnt_q;
  assign head   = e0_q;

endmodule

// File: rtl/fdc_front.sv
module fdc_front
  import fdc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [1:0]            bus_addr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  output logic [BYTE_W-1:0]     bus_rdata,
  output logic                  irq,
  output logic [NUM_DRIVES-1:0] motor_en,
  output logic                  dma_en,
  output logic [DSEL_W-1:0]     drive_sel,
  output logic [2*BYTE_W-1:0]   step_cfg
);

  logic                           hold, soft_rst;
  logic                           ctrl_wr, data_wr, data_pop;
  logic                           cmd_fire;
  logic [MAX_CMD-1:0][BYTE_W-1:0] cmd_bytes;
  logic                           res_load, res_two;
  logic [BYTE_W-1:0]              res_b0, res_b1, rq_head;
  logic                           dio;
  logic [1:0]                     rq_cnt;
  logic [BYTE_W-1:0]              msr;
  logic                           flush;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
  assign data_wr  = bus_wr && (bus_addr == ADDR_DATA) && !hold && !dio;
  assign data_pop = bus_rd && (bus_addr == ADDR_DATA) && dio;
  assign flush    = hold | soft_rst;

  fdc_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_wr),
    .wdata    (bus_wdata),
    .motor_en (motor_en),
    .dma_en   (dma_en),
    .drive_sel(drive_sel),
    .hold     (hold),
    .soft_rst (soft_rst)
  );

  fdc_cmd_collect u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (data_wr),
    .wdata    (bus_wdata),
    .fire     (cmd_fire),
    .cmd_bytes(cmd_bytes)
  );

  fdc_exec #(.TRACK_W(BYTE_W)) u_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .soft_rst (soft_rst),
    .fire     (cmd_fire),
    .cmd_bytes(cmd_bytes),
    .irq      (irq),
    .step_cfg (step_cfg),
    .res_load (res_load),
    .res_two  (res_two),
    .res_b0   (res_b0),
    .res_b1   (res_b1)
  );

  fdc_result_q u_results (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .load  (res_load),
    .two   (res_two),
    .b0    (res_b0),
    .b1    (res_b1),
    .pop   (data_pop),
    .to_cpu(dio),
    .count (rq_cnt),
    .head  (rq_head)
  );

  always_comb begin
    msr            = '0;
    msr[MSR_READY] = 1'b1;
    msr[MSR_TOCPU] = dio;
    msr[MSR_BUSY]  = dio;
  end

  always_comb begin
    case (bus_addr)
      ADDR_STAT: bus_rdata = msr;
      ADDR_DATA: bus_rdata = dio ? rq_head : READ_IDLE;
      default:   bus_rdata = READ_NONE;
    endcase
  end

endmodule

// File: rtl/fdc_front_chk.sv
module fdc_front_chk
  import fdc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       hold,
  input logic       soft_rst,
  input logic       fire,
  input logic [4:0] fire_op,
  input logic       irq,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic       dio,
  input logic [1:0] rq_cnt
);

  // R3: holding the controller forces the interrupt line low
  a_r3_hold_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !irq);

  // R4: leaving reset raises the interrupt line
  a_r4_release_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> irq);

  // R5: recalibrate posts an interrupt
  a_r5_recal_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fire_op == OP_RECAL && !hold) |=> irq);

  // R7: the line only falls after a hold or a sense command
  a_r7_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(hold) || $past(fire && fire_op == OP_SENSE)));

  // R9: each result read removes exactly one byte
  a_r9_pop_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_DATA && dio && !hold) |=> (rq_cnt == $past(rq_cnt) - 2'd1));

  // R9: never more than two result bytes queued
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rq_cnt <= 2'd2);

endmodule

bind fdc_front fdc_front_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hold    (hold),
  .soft_rst(soft_rst),
  .fire    (cmd_fire),
  .fire_op (cmd_bytes[0][4:0]),
  .irq     (irq),
  .bus_rd  (bus_rd),
  .bus_addr(bus_addr),
  .dio     (dio),
  .rq_cnt  (rq_cnt)
);

// File: tb/fdc_front_bench.sv
module fdc_front_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        irq;
  logic [3:0]  motor_en;
  logic        dma_en;
  logic [1:0]  drive_sel;
  logic [15:0] step_cfg;

  fdc_front u_fdc_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .motor_en (motor_en),
    .dma_en   (dma_en),
    .drive_sel(drive_sel),
    .step_cfg (step_cfg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t sb[$];
  event sample_ev;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] want);
    n_tests++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  // monitor: compares each sampled data-port read against the scoreboard
  initial begin
    exp_t e;
    forever begin
      @(sample_ev);
      if (sb.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R9 unexpected read: got %h expected none", bus_rdata);
      end else begin
        e = sb.pop_front();
        chk(e.tag, {8'h00, bus_rdata}, {8'h00, e.val});
      end
    end
  end

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_t e;
    e.val = v;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_data();
    @(negedge clk);
    bus_addr = 2'd2;
    bus_rd   = 1'b1;
    #(CLK_PERIOD / 4);
    ->sample_ev;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_status(output logic [7:0] v);
    @(negedge clk);
    bus_addr = 2'd1;
    bus_rd   = 1'b1;
    #(CLK_PERIOD / 4);
    v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic status_is(input logic [7:0] want, input string tag);
    logic [7:0] v;
    read_status(v);
    chk(tag, {8'h00, v}, {8'h00, want});
  endtask

  task automatic sense_two(input logic [7:0] st0, input logic [7:0] trk, input string tag);
    bus_write(2'd2, 8'h08);
    expect_byte(st0, tag);
    expect_byte(trk, tag);
    read_data();
    read_data();
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = 2'd0;
    bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 motor", {12'd0, motor_en}, 16'd0);
    chk("R1 dma", {15'd0, dma_en}, 16'd0);
    chk("R1 sel", {14'd0, drive_sel}, 16'd0);
    status_is(8'h80, "R1 status");
    // R10: empty data read
    expect_byte(8'h80, "R10 empty read");
    read_data();
    status_is(8'h80, "R10 no state change");

    // R3: writes during hold are ignored
    bus_write(2'd2, 8'h12);
    status_is(8'h80, "R3 hold ignores data");
    chk("R3 irq low", {15'd0, irq}, 16'd0);

    // R2: control fields, still held (bit 2 low)
    bus_write(2'd0, 8'hA9);
    chk("R2 motor", {12'd0, motor_en}, 16'h000A);
    chk("R2 dma", {15'd0, dma_en}, 16'd1);
    chk("R2 sel", {14'd0, drive_sel}, 16'd1);
    chk("R3 irq held", {15'd0, irq}, 16'd0);

    // R4: release from hold
    bus_write(2'd0, 8'h1C);
    chk("R4 irq raised", {15'd0, irq}, 16'd1);
    chk("R2 motor drive0", {12'd0, motor_en}, 16'h0001);

    // R7: drain the four reset events one at a time; R9/R13 on the first
    bus_write(2'd2, 8'h08);
    status_is(8'hD0, "R9 results queued");
    bus_write(2'd2, 8'h08);  // R13: must be ignored
    expect_byte(8'hC0, "R7 drive0 st0");
    read_data();
    status_is(8'hD0, "R9 one byte left");
    expect_byte(8'h00, "R7 drive0 track");
    read_data();
    status_is(8'h80, "R9 drained");
    chk("R7 irq still high", {15'd0, irq}, 16'd1);
    status_is(8'h80, "R13 stray byte ignored");
    sense_two(8'hC0, 8'h00, "R7 drive1");
    chk("R7 irq after 2", {15'd0, irq}, 16'd1);
    sense_two(8'hC0, 8'h00, "R7 drive2");
    chk("R7 irq after 3", {15'd0, irq}, 16'd1);
    sense_two(8'hC0, 8'h00, "R7 drive3");
    chk("R7 irq after last", {15'd0, irq}, 16'd0);

    // R8: nothing pending
    bus_write(2'd2, 8'h08);
    expect_byte(8'h80, "R8 none pending");
    read_data();
    status_is(8'h80, "R8 single byte");
    chk("R8 irq low", {15'd0, irq}, 16'd0);

    // R6: seek drive 2 head 1 to cylinder 0x27
    bus_write(2'd2, 8'h0F);
    bus_write(2'd2, 8'h06);
    chk("R6 no irq before last byte", {15'd0, irq}, 16'd0);
    bus_write(2'd2, 8'h27);
    chk("R6 irq", {15'd0, irq}, 16'd1);
    status_is(8'h80, "R6 no result");
    sense_two(8'h06, 8'h27, "R6 seek report");
    chk("R6 irq cleared", {15'd0, irq}, 16'd0);

    // R5: recalibrate drive 2
    bus_write(2'd2, 8'h07);
    bus_write(2'd2, 8'h02);
    chk("R5 irq", {15'd0, irq}, 16'd1);
    status_is(8'h80, "R5 no result");
    sense_two(8'h02, 8'h00, "R5 recal report");

    // R7: two drives pending, lowest first, each with its own track
    bus_write(2'd2, 8'h0F);
    bus_write(2'd2, 8'h07);
    bus_write(2'd2, 8'h09);
    bus_write(2'd2, 8'h0F);
    bus_write(2'd2, 8'h01);
    bus_write(2'd2, 8'h05);
    sense_two(8'h01, 8'h05, "R7 lowest first");
    chk("R7 irq one left", {15'd0, irq}, 16'd1);
    sense_two(8'h07, 8'h09, "R7 second drive");
    chk("R7 irq none left", {15'd0, irq}, 16'd0);

    // R11: parameter setup
    bus_write(2'd2, 8'h03);
    bus_write(2'd2, 8'hAF);
    bus_write(2'd2, 8'h02);
    chk("R11 step_cfg", step_cfg, 16'hAF02);
    status_is(8'h80, "R11 no result");

    // R12: unsupported opcode
    bus_write(2'd2, 8'h12);
    status_is(8'hD0, "R12 result queued");
    expect_byte(8'h80, "R12 invalid byte");
    read_data();
    status_is(8'h80, "R12 single byte");

    // R3: hold with irq high drops it; R4 again on release
    bus_write(2'd2, 8'h07);
    bus_write(2'd2, 8'h01);
    chk("R5 irq before hold", {15'd0, irq}, 16'd1);
    bus_write(2'd0, 8'h00);
    chk("R3 hold drops irq", {15'd0, irq}, 16'd0);
    bus_write(2'd0, 8'h04);
    chk("R4 irq on second release", {15'd0, irq}, 16'd1);
    sense_two(8'hC0, 8'h00, "R4 status after release");

    chk("R9 scoreboard empty", 16'(sb.size()), 16'd0);
    finish_run();
  end

endmodule